// File: doc/BRIEF.md
# Two-Port Read Switch with ID Tagging

This block joins the read side of two bus initiators to a single read target. Both initiators present read requests on their own address channels. A round-robin arbiter picks one request at a time and passes it to the target. On the way out, the request ID gains one extra top bit that holds the number of the initiator the request came from.

Read data returns from the target beat by beat. The extra ID bit tells the switch which initiator owns each beat, and the switch removes that bit before the beat reaches the initiator. The return path holds no state and no storage. Each beat reaches its initiator in the same cycle it leaves the target. Back-pressure comes from the owning initiator's ready signal.

Every channel uses a valid/ready handshake. A transfer happens only in a cycle where both valid and ready are high. A source keeps valid high, with a stable payload, until that transfer happens.

Top module: `rd_id_switch`

## Requirements
- R1: A forwarded request carries `t_arid = {p, id}`, where p is the initiator index (0 for the i0 port, 1 for the i1 port) and id is that initiator's `arid`. The address, length, size and burst fields of the winning initiator pass through unchanged.
- R2: At most one initiator sees `arready` high in any cycle. An initiator's `arready` is high only when its request is the one forwarded and `t_arready` is high. `t_arvalid` is low when neither initiator requests.
- R3: When both initiators request in a cycle where no grant is held, the initiator that did not complete the most recent forwarded handshake wins.
- R4: After a request is forwarded, the grant stays with that initiator until its handshake completes. While `t_arready` is low, `t_arid` and `t_araddr` stay stable, even if the other initiator starts requesting.
- R5: For a beat with `t_rvalid` high, bit IW of `t_rid` selects the initiator: 0 selects i0 and 1 selects i1. That initiator sees `rvalid` high and the other sees it low. Both initiators receive `rid = t_rid[IW-1:0]` together with `rdata`, `rresp` and `rlast` copied from the target.
- R6: `t_rready` equals the `rready` of the initiator selected by the current beat. The other initiator's `rready` has no effect on it.
- R7: After reset, no valid is driven toward the target or toward the initiators until an input requests. The first contended grant goes to initiator 0.
- R8: Beats reach each initiator in the order the target sends them, in the same cycle, with no buffering. Interleaved beats for different IDs therefore keep the target's order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i0_arvalid | input | 1 | Initiator 0 request valid |
| i0_arready | output | 1 | Initiator 0 request accepted |
| i0_arid | input | IW | Initiator 0 request ID |
| i0_araddr | input | AW | Initiator 0 start address |
| i0_arlen | input | 8 | Initiator 0 beat count minus one |
| i0_arsize | input | 3 | Initiator 0 beat size code |
| i0_arburst | input | 2 | Initiator 0 burst type |
| i0_rvalid | output | 1 | Beat valid for initiator 0 |
| i0_rready | input | 1 | Initiator 0 accepts beat |
| i0_rid | output | IW | Beat ID with the index bit removed |
| i0_rdata | output | DW | Beat data |
| i0_rresp | output | 2 | Beat response |
| i0_rlast | output | 1 | Final beat of the burst |
| i1_arvalid | input | 1 | Initiator 1 request valid |
| i1_arready | output | 1 | Initiator 1 request accepted |
| i1_arid | input | IW | Initiator 1 request ID |
| i1_araddr | input | AW | Initiator 1 start address |
| i1_arlen | input | 8 | Initiator 1 beat count minus one |
| i1_arsize | input | 3 | Initiator 1 beat size code |
| i1_arburst | input | 2 | Initiator 1 burst type |
| i1_rvalid | output | 1 | Beat valid for initiator 1 |
| i1_rready | input | 1 | Initiator 1 accepts beat |
| i1_rid | output | IW | Beat ID with the index bit removed |
| i1_rdata | output | DW | Beat data |
| i1_rresp | output | 2 | Beat response |
| i1_rlast | output | 1 | Final beat of the burst |
| t_arvalid | output | 1 | Request valid toward the target |
| t_arready | input | 1 | Target accepts request |
| t_arid | output | IW+1 | Tagged request ID |
| t_araddr | output | AW | Forwarded start address |
| t_arlen | output | 8 | Forwarded length |
| t_arsize | output | 3 | Forwarded size |
| t_arburst | output | 2 | Forwarded burst type |
| t_rvalid | input | 1 | Target beat valid |
| t_rready | output | 1 | Beat accepted by the selected initiator |
| t_rid | input | IW+1 | Tagged beat ID |
| t_rdata | input | DW | Target beat data |
| t_rresp | input | 2 | Target beat response |
| t_rlast | input | 1 | Target final-beat flag |

## Verification
The arbiter's grant-held flag and its favored-port pointer are the only state in the block.

A wrong favored pointer shows at the ports on the next contended cycle. The target then receives the two tags in the wrong order, and the first request after reset already exposes a wrong reset value. A grant flag that is not held shows during a target stall. In the cycle after the second initiator starts requesting, `t_arid` changes while `t_arvalid` is still high.

Routing faults need no history. They appear on the same beat as a wrong `rvalid` owner, an unstripped `rid`, or a `t_rready` that follows the wrong initiator.

// File: rtl/rdsw_pkg.sv
package rdsw_pkg;

    localparam int NPORT   = 2;
    localparam int PIDX_W  = 1;
    localparam int LEN_W   = 8;
    localparam int SIZE_W  = 3;
    localparam int BURST_W = 2;
    localparam int RESP_W  = 2;

    typedef logic [PIDX_W-1:0]  port_idx_t;
    typedef logic [LEN_W-1:0]   len_t;
    typedef logic [SIZE_W-1:0]  size_t;
    typedef logic [BURST_W-1:0] burst_t;
    typedef logic [RESP_W-1:0]  resp_t;

    // Request fields that pass through untouched.
    typedef struct packed {
        len_t   len;
        size_t  size;
        burst_t burst;
    } ar_shape_t;

    // Beat fields shared by both initiators.
    typedef struct packed {
        resp_t resp;
        logic  last;
    } r_tail_t;

    typedef enum logic {
        ARB_OPEN = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;

    // The favored port wins if it requests; otherwise the other port is picked.
    function automatic port_idx_t rr_choose(input logic [NPORT-1:0] req,
                                            input port_idx_t favored);
        if (req[favored]) begin
            return favored;
        end
        return port_idx_t'(~favored);
    endfunction

endpackage

// File: rtl/rdsw_rr_arb.sv
module rdsw_rr_arb
    import rdsw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] req,
    input  logic             fwd_ready,
    output logic             gnt_valid,
    output port_idx_t        gnt_idx
);

    arb_state_e state_q;
    port_idx_t  owner_q;
    port_idx_t  favored_q;
    port_idx_t  pick;

    always_comb begin
        pick      = rr_choose(req, favored_q);
        gnt_idx   = (state_q == ARB_HELD) ? owner_q : pick;
        gnt_valid = req[gnt_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ARB_OPEN;
            owner_q   <= '0;
            favored_q <= '0;
        end else if (gnt_valid) begin
            if (fwd_ready) begin
                state_q   <= ARB_OPEN;
                favored_q <= port_idx_t'(~gnt_idx);
            end else begin
                state_q   <= ARB_HELD;
                owner_q   <= gnt_idx;
            end
        end
    end

endmodule

// File: rtl/rdsw_ar_mux.sv
module rdsw_ar_mux
    import rdsw_pkg::*;
#(
    parameter int IW = 4,
    parameter int AW = 32
) (
    input  logic [NPORT-1:0][IW-1:0] in_id,
    input  logic [NPORT-1:0][AW-1:0] in_addr,
    input  ar_shape_t [NPORT-1:0]    in_shape,
    input  logic                     gnt_valid,
    input  port_idx_t                gnt_idx,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [IW+PIDX_W-1:0]     out_id,
    output logic [AW-1:0]            out_addr,
    output ar_shape_t                out_shape,
    output logic [NPORT-1:0]         in_ready
);

    assign out_valid = gnt_valid;
    assign out_id    = {gnt_idx, in_id[gnt_idx]};
    assign out_addr  = in_addr[gnt_idx];
    assign out_shape = in_shape[gnt_idx];

    for (genvar p = 0; p < NPORT; p++) begin : g_ready
        assign in_ready[p] = out_ready && gnt_valid && (gnt_idx == port_idx_t'(p));
    end

endmodule

// File: rtl/rdsw_r_demux.sv
module rdsw_r_demux
    import rdsw_pkg::*;
#(
    parameter int IW = 4,
    parameter int DW = 32
) (
    input  logic                 t_valid,
    input  logic [IW+PIDX_W-1:0] t_id,
    input  logic [DW-1:0]        t_data,
    input  r_tail_t              t_tail,
    input  logic [NPORT-1:0]     in_ready,
    output logic [NPORT-1:0]     out_valid,
    output logic [IW-1:0]        out_id,
    output logic [DW-1:0]        out_data,
    output r_tail_t              out_tail,
    output logic                 t_ready
);

    localparam int TW = IW + PIDX_W;

    port_idx_t route;

    assign route    = t_id[TW-1 -: PIDX_W];
    assign out_id   = t_id[IW-1:0];
    assign out_data = t_data;
    assign out_tail = t_tail;
    assign t_ready  = in_ready[route];

    for (genvar p = 0; p < NPORT; p++) begin : g_valid
        assign out_valid[p] = t_valid && (route == port_idx_t'(p));
    end

endmodule

// File: rtl/rd_id_switch.sv
module rd_id_switch
    import rdsw_pkg::*;
#(
    parameter int IW = 4,
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i0_arvalid,
    output logic                 i0_arready,
    input  logic [IW-1:0]        i0_arid,
    input  logic [AW-1:0]        i0_araddr,
    input  logic [LEN_W-1:0]     i0_arlen,
    input  logic [SIZE_W-1:0]    i0_arsize,
    input  logic [BURST_W-1:0]   i0_arburst,
    output logic                 i0_rvalid,
    input  logic                 i0_rready,
    output logic [IW-1:0]        i0_rid,
    output logic [DW-1:0]        i0_rdata,
    output logic [RESP_W-1:0]    i0_rresp,
    output logic                 i0_rlast,
    input  logic                 i1_arvalid,
    output logic                 i1_arready,
    input  logic [IW-1:0]        i1_arid,
    input  logic [AW-1:0]        i1_araddr,
    input  logic [LEN_W-1:0]     i1_arlen,
    input  logic [SIZE_W-1:0]    i1_arsize,
    input  logic [BURST_W-1:0]   i1_arburst,
    output logic                 i1_rvalid,
    input  logic                 i1_rready,
    output logic [IW-1:0]        i1_rid,
    output logic [DW-1:0]        i1_rdata,
    output logic [RESP_W-1:0]    i1_rresp,
    output logic                 i1_rlast,
    output logic                 t_arvalid,
    input  logic                 t_arready,
    output logic [IW+PIDX_W-1:0] t_arid,
    output logic [AW-1:0]        t_araddr,
    output logic [LEN_W-1:0]     t_arlen,
    output logic [SIZE_W-1:0]    t_arsize,
    output logic [BURST_W-1:0]   t_arburst,
    input  logic                 t_rvalid,
    output logic                 t_rready,
    input  logic [IW+PIDX_W-1:0] t_rid,
    input  logic [DW-1:0]        t_rdata,
    input  logic [RESP_W-1:0]    t_rresp,
    input  logic                 t_rlast
);

    // Request side: gather per-port fields into arrays.
    logic [NPORT-1:0]          ar_req;
    logic [NPORT-1:0][IW-1:0]  ar_id;
    logic [NPORT-1:0][AW-1:0]  ar_addr;
    ar_shape_t [NPORT-1:0]     ar_shape;
    logic [NPORT-1:0]          ar_rdy;
    ar_shape_t                 fwd_shape;
    logic                      gnt_valid;
    port_idx_t                 gnt_idx;

    assign ar_req      = {i1_arvalid, i0_arvalid};
    assign ar_id       = {i1_arid, i0_arid};
    assign ar_addr     = {i1_araddr, i0_araddr};
    assign ar_shape[0] = '{len: i0_arlen, size: i0_arsize, burst: i0_arburst};
    assign ar_shape[1] = '{len: i1_arlen, size: i1_arsize, burst: i1_arburst};

    rdsw_rr_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (ar_req),
        .fwd_ready (t_arready),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    rdsw_ar_mux #(.IW(IW), .AW(AW)) u_ar_mux (
        .in_id     (ar_id),
        .in_addr   (ar_addr),
        .in_shape  (ar_shape),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .out_ready (t_arready),
        .out_valid (t_arvalid),
        .out_id    (t_arid),
        .out_addr  (t_araddr),
        .out_shape (fwd_shape),
        .in_ready  (ar_rdy)
    );

    assign t_arlen    = fwd_shape.len;
    assign t_arsize   = fwd_shape.size;
    assign t_arburst  = fwd_shape.burst;
    assign i0_arready = ar_rdy[0];
    assign i1_arready = ar_rdy[1];

    // Return side: steer by the tag bit, strip it, share the payload.
    r_tail_t          tail_in;
    r_tail_t          tail_out;
    logic [NPORT-1:0] r_vld;
    logic [IW-1:0]    r_id;
    logic [DW-1:0]    r_data;

    assign tail_in = '{resp: t_rresp, last: t_rlast};

    rdsw_r_demux #(.IW(IW), .DW(DW)) u_r_demux (
        .t_valid   (t_rvalid),
        .t_id      (t_rid),
        .t_data    (t_rdata),
        .t_tail    (tail_in),
        .in_ready  ({i1_rready, i0_rready}),
        .out_valid (r_vld),
        .out_id    (r_id),
        .out_data  (r_data),
        .out_tail  (tail_out),
        .t_ready   (t_rready)
    );

    assign i0_rvalid = r_vld[0];
    assign i1_rvalid = r_vld[1];
    assign i0_rid    = r_id;
    assign i1_rid    = r_id;
    assign i0_rdata  = r_data;
    assign i1_rdata  = r_data;
    assign i0_rresp  = tail_out.resp;
    assign i1_rresp  = tail_out.resp;
    assign i0_rlast  = tail_out.last;
    assign i1_rlast  = tail_out.last;

endmodule

// File: rtl/rdsw_sva.sv
module rdsw_sva #(
    parameter int IW = 4,
    parameter int DW = 32,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          i0_arvalid,
    input logic          i0_arready,
    input logic [IW-1:0] i0_arid,
    input logic [AW-1:0] i0_araddr,
    input logic          i1_arvalid,
    input logic          i1_arready,
    input logic [IW-1:0] i1_arid,
    input logic [AW-1:0] i1_araddr,
    input logic          i0_rvalid,
    input logic          i0_rready,
    input logic [IW-1:0] i0_rid,
    input logic          i1_rvalid,
    input logic          i1_rready,
    input logic [IW-1:0] i1_rid,
    input logic          t_arvalid,
    input logic          t_arready,
    input logic [IW:0]   t_arid,
    input logic [AW-1:0] t_araddr,
    input logic          t_rvalid,
    input logic          t_rready,
    input logic [IW:0]   t_rid
);

    // R1: the tag bit names a requesting initiator whose ID and address are forwarded
    a_r1_id_prefix: assert property (@(posedge clk) disable iff (rst)
        t_arvalid |-> (t_arid[IW]
            ? (i1_arvalid && t_arid[IW-1:0] == i1_arid && t_araddr == i1_araddr)
            : (i0_arvalid && t_arid[IW-1:0] == i0_arid && t_araddr == i0_araddr)));

    // R2: never both initiators accepted at once
    a_r2_single_ready: assert property (@(posedge clk) disable iff (rst)
        !(i0_arready && i1_arready));

    // R2: acceptance only for the forwarded owner while the target is ready
    a_r2_ready_owner: assert property (@(posedge clk) disable iff (rst)
        (i0_arready || i1_arready) |->
            (t_arvalid && t_arready && (t_arid[IW] == i1_arready)));

    // R3: after a forwarded handshake, a contended grant goes to the other port
    a_r3_alternate: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(t_arvalid && t_arready) && i0_arvalid && i1_arvalid)
            |-> (t_arid[IW] != $past(t_arid[IW])));

    // R4: a stalled request stays in place
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (t_arvalid && !t_arready) |=>
            (t_arvalid && $stable(t_arid) && $stable(t_araddr)));

    // R5: exactly the tagged initiator sees the beat
    a_r5_route: assert property (@(posedge clk) disable iff (rst)
        t_rvalid |-> (t_rid[IW] ? (i1_rvalid && !i0_rvalid) : (i0_rvalid && !i1_rvalid)));

    // R5: no beat toward any initiator without a target beat
    a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
        !t_rvalid |-> (!i0_rvalid && !i1_rvalid));

    // R5: tag bit removed from the delivered ID
    a_r5_strip: assert property (@(posedge clk) disable iff (rst)
        t_rvalid |-> (i0_rid == t_rid[IW-1:0] && i1_rid == t_rid[IW-1:0]));

    // R6: target back-pressure follows the selected initiator
    a_r6_ready: assert property (@(posedge clk) disable iff (rst)
        t_rvalid |-> (t_rready == (t_rid[IW] ? i1_rready : i0_rready)));

endmodule

bind rd_id_switch rdsw_sva #(.IW(IW), .DW(DW), .AW(AW)) u_sva (.*);

// File: tb/rd_id_switch_tb.sv
module rd_id_switch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IW  = 4;
    localparam int DW  = 32;
    localparam int AW  = 32;
    localparam int ARW = IW + 1 + AW + 8 + 3 + 2;
    localparam int RW  = IW + DW + 2 + 1;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic          ar_v     [2];
    logic          ar_rdy   [2];
    logic [IW-1:0] ar_id    [2];
    logic [AW-1:0] ar_addr  [2];
    logic [7:0]    ar_len   [2];
    logic [2:0]    ar_size  [2];
    logic [1:0]    ar_burst [2];
    logic          rv       [2];
    logic          rr       [2];
    logic [IW-1:0] rid      [2];
    logic [DW-1:0] rdata    [2];
    logic [1:0]    rresp    [2];
    logic          rlast    [2];

    logic          t_arvalid;
    logic          tar_rdy;
    logic [IW:0]   t_arid;
    logic [AW-1:0] t_araddr;
    logic [7:0]    t_arlen;
    logic [2:0]    t_arsize;
    logic [1:0]    t_arburst;
    logic          tr_v;
    logic          t_rready;
    logic [IW:0]   tr_id;
    logic [DW-1:0] tr_data;
    logic [1:0]    tr_resp;
    logic          tr_last;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    logic [ARW-1:0] arq [$];
    logic [RW-1:0]  rq0 [$];
    logic [RW-1:0]  rq1 [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rd_id_switch #(.IW(IW), .DW(DW), .AW(AW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .i0_arvalid (ar_v[0]),
        .i0_arready (ar_rdy[0]),
        .i0_arid    (ar_id[0]),
        .i0_araddr  (ar_addr[0]),
        .i0_arlen   (ar_len[0]),
        .i0_arsize  (ar_size[0]),
        .i0_arburst (ar_burst[0]),
        .i0_rvalid  (rv[0]),
        .i0_rready  (rr[0]),
        .i0_rid     (rid[0]),
        .i0_rdata   (rdata[0]),
        .i0_rresp   (rresp[0]),
        .i0_rlast   (rlast[0]),
        .i1_arvalid (ar_v[1]),
        .i1_arready (ar_rdy[1]),
        .i1_arid    (ar_id[1]),
        .i1_araddr  (ar_addr[1]),
        .i1_arlen   (ar_len[1]),
        .i1_arsize  (ar_size[1]),
        .i1_arburst (ar_burst[1]),
        .i1_rvalid  (rv[1]),
        .i1_rready  (rr[1]),
        .i1_rid     (rid[1]),
        .i1_rdata   (rdata[1]),
        .i1_rresp   (rresp[1]),
        .i1_rlast   (rlast[1]),
        .t_arvalid  (t_arvalid),
        .t_arready  (tar_rdy),
        .t_arid     (t_arid),
        .t_araddr   (t_araddr),
        .t_arlen    (t_arlen),
        .t_arsize   (t_arsize),
        .t_arburst  (t_arburst),
        .t_rvalid   (tr_v),
        .t_rready   (t_rready),
        .t_rid      (tr_id),
        .t_rdata    (tr_data),
        .t_rresp    (tr_resp),
        .t_rlast    (tr_last)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Scoreboard pushes: predicted target-side request, predicted delivered beat.
    task automatic exp_ar(input int p, input logic [IW-1:0] id,
                          input logic [AW-1:0] addr, input logic [7:0] len);
        arq.push_back({p[0], id, addr, len, 3'd2, 2'd1});
    endtask

    task automatic ar_send(input int p, input logic [IW-1:0] id,
                           input logic [AW-1:0] addr, input logic [7:0] len);
        @(negedge clk);
        ar_v[p] = 1'b1; ar_id[p] = id; ar_addr[p] = addr;
        ar_len[p] = len; ar_size[p] = 3'd2; ar_burst[p] = 2'd1;
        forever begin
            #1;
            if (ar_rdy[p]) break;
            @(negedge clk);
        end
        @(negedge clk);
        ar_v[p] = 1'b0;
    endtask

    task automatic beat(input int p, input logic [IW-1:0] id, input logic [DW-1:0] data,
                        input logic [1:0] resp, input logic last);
        if (p == 0) rq0.push_back({id, data, resp, last});
        else        rq1.push_back({id, data, resp, last});
        @(negedge clk);
        tr_v = 1'b1; tr_id = {p[0], id}; tr_data = data; tr_resp = resp; tr_last = last;
        forever begin
            #1;
            if (t_rready) break;
            @(negedge clk);
        end
        @(negedge clk);
        tr_v = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever a transfer happens at a port.
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            if (t_arvalid && tar_rdy) begin
                if (arq.size() == 0) begin
                    chk(1'b0, "R1 unexpected request", 64'(t_arid), 64'(0));
                end else begin
                    logic [ARW-1:0] got;
                    logic [ARW-1:0] exp;
                    got = {t_arid, t_araddr, t_arlen, t_arsize, t_arburst};
                    exp = arq.pop_front();
                    chk(got === exp, "R1/R3 forwarded request", 64'(got), 64'(exp));
                end
            end
            for (int p = 0; p < 2; p++) begin
                if (rv[p] && rr[p]) begin
                    logic [RW-1:0] got;
                    logic [RW-1:0] exp;
                    got = {rid[p], rdata[p], rresp[p], rlast[p]};
                    if (p == 0 && rq0.size() > 0)      exp = rq0.pop_front();
                    else if (p == 1 && rq1.size() > 0) exp = rq1.pop_front();
                    else                               exp = 'x;
                    chk(got === exp, "R5/R8 delivered beat", 64'(got), 64'(exp));
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            summary();
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            ar_v[p] = 0; ar_id[p] = 0; ar_addr[p] = 0; ar_len[p] = 0;
            ar_size[p] = 0; ar_burst[p] = 0; rr[p] = 1'b1;
        end
        tar_rdy = 1'b1; tr_v = 0; tr_id = 0; tr_data = 0; tr_resp = 0; tr_last = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R7: quiet outputs after reset
        chk(!t_arvalid, "R7 t_arvalid after reset", 64'(t_arvalid), 64'(0));
        chk(!ar_rdy[0] && !ar_rdy[1], "R7 arready after reset",
            64'({ar_rdy[1], ar_rdy[0]}), 64'(0));
        chk(!rv[0] && !rv[1], "R7 rvalid after reset", 64'({rv[1], rv[0]}), 64'(0));

        // R7/R3: first contention goes to port 0, then port 1
        exp_ar(0, 4'h3, 32'h0000_1000, 8'd3);
        exp_ar(1, 4'h3, 32'h0000_2000, 8'd0);
        fork
            ar_send(0, 4'h3, 32'h0000_1000, 8'd3);
            ar_send(1, 4'h3, 32'h0000_2000, 8'd0);
        join

        // R1: lone requests from each port, all-ones ID on port 1
        exp_ar(1, 4'hF, 32'hDEAD_BEE0, 8'd7);
        ar_send(1, 4'hF, 32'hDEAD_BEE0, 8'd7);
        exp_ar(0, 4'h0, 32'hFFFF_FFFC, 8'd255);
        ar_send(0, 4'h0, 32'hFFFF_FFFC, 8'd255);

        // R3: port 0 won last, so sustained contention starts with port 1
        for (int k = 0; k < 3; k++) begin
            exp_ar(1, 4'(8 + k), 32'h0001_0000 + 32'(k * 16), 8'(k));
            exp_ar(0, 4'(1 + k), 32'h0002_0000 + 32'(k * 16), 8'(k));
        end
        fork
            for (int k = 0; k < 3; k++) ar_send(0, 4'(1 + k), 32'h0002_0000 + 32'(k * 16), 8'(k));
            for (int k = 0; k < 3; k++) ar_send(1, 4'(8 + k), 32'h0001_0000 + 32'(k * 16), 8'(k));
        join

        // R4: port 0 granted while the target stalls; port 1 arrives and must wait
        tar_rdy = 1'b0;
        exp_ar(0, 4'h6, 32'h0003_0000, 8'd1);
        exp_ar(1, 4'h9, 32'h0004_0000, 8'd2);
        @(negedge clk);
        ar_v[0] = 1'b1; ar_id[0] = 4'h6; ar_addr[0] = 32'h0003_0000; ar_len[0] = 8'd1;
        #1;
        chk(t_arvalid && t_arid == 5'h06, "R4 grant taken", 64'(t_arid), 64'h06);
        @(negedge clk);
        ar_v[1] = 1'b1; ar_id[1] = 4'h9; ar_addr[1] = 32'h0004_0000; ar_len[1] = 8'd2;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(t_arvalid && t_arid == 5'h06 && t_araddr == 32'h0003_0000,
                "R4 grant held during stall", 64'(t_arid), 64'h06);
            chk(!ar_rdy[0] && !ar_rdy[1], "R2 no arready while target stalls",
                64'({ar_rdy[1], ar_rdy[0]}), 64'(0));
            @(negedge clk);
        end
        tar_rdy = 1'b1;
        #1;
        chk(ar_rdy[0] && !ar_rdy[1], "R2 only owner accepted",
            64'({ar_rdy[1], ar_rdy[0]}), 64'h1);
        @(negedge clk);
        ar_v[0] = 1'b0;
        #1;
        chk(ar_rdy[1] && t_arid == 5'h19, "R2 waiting port served next", 64'(t_arid), 64'h19);
        @(negedge clk);
        ar_v[1] = 1'b0;
        #1;
        chk(!t_arvalid, "R2 idle when nobody requests", 64'(t_arvalid), 64'(0));

        // R5: beats for each port, rlast and resp carried
        beat(0, 4'h2, 32'hA5A5_0001, 2'd0, 1'b0);
        beat(0, 4'h2, 32'hA5A5_0002, 2'd0, 1'b1);
        beat(1, 4'h5, 32'h5A5A_0003, 2'd2, 1'b1);

        // R8: interleaved IDs across ports keep the target's order
        for (int k = 0; k < 6; k++) begin
            beat(k % 2, 4'(k), 32'hC000_0000 + 32'(k), 2'(k), (k >= 4));
        end

        // R6: port 1 stalls its beat; port 0 ready must not leak through
        rr[1] = 1'b0; rr[0] = 1'b1;
        fork
            beat(1, 4'hB, 32'h1234_5678, 2'd1, 1'b1);
            begin
                @(negedge clk);
                for (int k = 0; k < 3; k++) begin
                    #1;
                    chk(!t_rready, "R6 other rready ignored", 64'(t_rready), 64'(0));
                    chk(rv[1] && !rv[0], "R5 beat routed to port 1",
                        64'({rv[1], rv[0]}), 64'h2);
                    chk(rid[1] == 4'hB, "R5 ID stripped", 64'(rid[1]), 64'hB);
                    @(negedge clk);
                end
                rr[1] = 1'b1;
            end
        join

        repeat (3) @(negedge clk);
        chk(arq.size() == 0, "R1 all requests forwarded", 64'(arq.size()), 64'(0));
        chk(rq0.size() == 0 && rq1.size() == 0, "R8 all beats delivered",
            64'(rq0.size() + rq1.size()), 64'(0));
        done = 1'b1;
        summary();
        $finish;
    end

endmodule